// File: doc/BRIEF.md
# Serial Clock Synthesizer Programmer

This block loads a new setting into an external clock synthesizer whose serial port is reached only through one 8-bit control register. The register is written by the block and latched by the synthesizer on a strobe. Each write puts a new value on the register bus, and one cycle later the block raises a one-cycle strobe. The serial data line is control bit 2 and the serial clock line is control bit 3. Both are also brought out as separate pins.

A single `start` pulse captures three values: a location address, a 13-bit programming word and the control value currently in use. The block then runs a fixed sequence:

- It clears the control register and blanks the display, then waits a guard time.
- It writes a two-step preamble of 0 and then 1.
- It sends a 21-bit serial stream. Each bit takes two strobed writes: one with the clock low, then one with the clock high.
- After a short wait it releases the blank and writes back the saved control value with bit 6 set.
- After a long settling wait it selects the new location: the low four address bits, with bit 6 set.
- It pulses `done`.

All waits are parameters counted in clock cycles.

Top module: `clkprog_serial`

## Requirements
- R1: After reset, `ctl_o`, `strobe_o`, `blank_o`, `done_o`, `sdat_o` and `sclk_o` are all zero.
- R2: A `start` pulse while idle captures `loc_addr`, `prog_word` and `ctl_in`. The first write puts 0x00 on `ctl_o` and raises `blank_o`, and this write is strobed.
- R3: Every control write is followed, one cycle later, by a strobe that is high for exactly one cycle. `ctl_o` does not change while the strobe is high. Within the transfer, back-to-back writes are spaced PHASE_CYC cycles apart.
- R4: From the clearing write to the first preamble write, the gap is PHASE_CYC + BLANK_CYC cycles.
- R5: The preamble consists of a write of 0x00 followed by a write of 0x01.
- R6: The serial stream is sent in this order: the bits 1, 0, 0; then `loc_addr` least significant bit first; then `prog_word` least significant bit first. Each bit d takes two writes, 0x01 | d<<2 (clock bit 3 low) and then 0x09 | d<<2 (clock bit 3 high). `sdat_o` always equals `ctl_o[2]` and `sclk_o` always equals `ctl_o[3]`. `blank_o` stays high for the whole stream.
- R7: After the last clock-high write, the block waits PHASE_CYC + POST_CYC cycles. It then writes the saved `ctl_in` value with bit 6 set, and in the same cycle drops `blank_o`.
- R8: After a further PHASE_CYC + SETTLE_CYC cycles, the block writes `{4'b0, loc_addr[3:0]}` with bit 6 set. That value then stays on `ctl_o`.
- R9: `done_o` is high for exactly one cycle, PHASE_CYC cycles after the final write. There is exactly one such pulse per transfer, and no further strobe follows it.
- R10: A `start` pulse that arrives during a transfer has no effect on the values written or on their timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (accepted only while idle) |
| loc_addr | input | 5 | Synthesizer location to program and then select |
| prog_word | input | 13 | Programming word to send |
| ctl_in | input | 8 | Current control register value, saved and later restored |
| ctl_o | output | 8 | Control register value |
| strobe_o | output | 1 | One-cycle latch strobe for `ctl_o` |
| sdat_o | output | 1 | Serial data line (control bit 2) |
| sclk_o | output | 1 | Serial clock line (control bit 3) |
| blank_o | output | 1 | Display blank request |
| done_o | output | 1 | One-cycle pulse when the sequence ends |

## Verification
The bench tests the stream at its extremes: an all-zero address and word, an all-ones pair, and a mixed pattern. Together these catch a design that sends most significant bit first, drops or repeats a start bit, or sends the clock-high phase before the clock-low phase. It measures the gap between strobes at each guard wait, so that an off-by-one in the cycle counting or a guard wait that is skipped shows up as a wrong gap. It also checks that the restore write ORs bit 6 into the saved value even when that bit is already set, and that `blank_o` drops on that restore write and not earlier. A second `start` is injected in the middle of a transfer: a design that re-captured the inputs would write different address bits, and a design that restarted would produce extra strobes.

// File: rtl/clkprog_pkg.sv
package clkprog_pkg;
  localparam int CTL_W   = 8;
  localparam int ANC_POS = 0;  // held high after the preamble
  localparam int DAT_POS = 2;  // serial data line
  localparam int CLK_POS = 3;  // serial clock line

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_GRD1, S_PRE0, S_PRE1,
    S_BLO, S_BHI, S_TAIL, S_RST, S_GRD2, S_FIN
  } state_e;

  function automatic logic [CTL_W-1:0] bit_word(input logic d, input logic c);
    logic [CTL_W-1:0] w;
    w = '0;
    w[ANC_POS] = 1'b1;
    w[DAT_POS] = d;
    w[CLK_POS] = c;
    return w;
  endfunction
endpackage

// File: rtl/clkprog_timer.sv
module clkprog_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R4: guard waits count down one per cycle
  a_r4_countdown: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/clkprog_shifter.sv
module clkprog_shifter #(
  parameter int N = 21
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] din,
  input  logic         adv,
  output logic         cur_bit,
  output logic         nxt_bit,
  output logic         last
);
  localparam int IW = $clog2(N);
  logic [N-1:0]  sr;
  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      idx <= '0;
    end else if (load) begin
      sr  <= din;
      idx <= '0;
    end else if (adv) begin
      sr  <= {1'b0, sr[N-1:1]};
      idx <= idx + 1'b1;
    end
  end

  assign cur_bit = sr[0];
  assign nxt_bit = sr[1];
  assign last    = (idx == IW'(N-1));

  // R6: never shift beyond the final stream bit
  a_r6_no_overshift: assert property (@(posedge clk) disable iff (rst)
    adv |-> !last);
  a_r6_load_adv_excl: assert property (@(posedge clk) disable iff (rst)
    !(load && adv));
endmodule

// File: rtl/clkprog_serial.sv
module clkprog_serial
  import clkprog_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int WORD_W     = 13,
  parameter int STB_POS    = 6,
  parameter int PHASE_CYC  = 4,        // must be 3 or more
  parameter int BLANK_CYC  = 1500000,
  parameter int POST_CYC   = 100000,
  parameter int SETTLE_CYC = 5000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [WORD_W-1:0] prog_word,
  input  logic [CTL_W-1:0]  ctl_in,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              strobe_o,
  output logic              sdat_o,
  output logic              sclk_o,
  output logic              blank_o,
  output logic              done_o
);
  localparam int NBITS = 3 + ADDR_W + WORD_W;
  localparam int MAXD  = (BLANK_CYC > SETTLE_CYC)
                         ? ((BLANK_CYC > POST_CYC) ? BLANK_CYC : POST_CYC)
                         : ((SETTLE_CYC > POST_CYC) ? SETTLE_CYC : POST_CYC);
  localparam int TW    = $clog2(MAXD + PHASE_CYC + 1);
  localparam int SEL_W = (ADDR_W < 4) ? ADDR_W : 4;
  localparam logic [CTL_W-1:0] STB_MASK = CTL_W'(1) << STB_POS;

  state_e             st;
  logic [CTL_W-1:0]   ctl_q, saved_q;
  logic [ADDR_W-1:0]  loc_q;
  logic               pend, strobe_q, blank_q, done_q;
  logic               tz, tmr_load;
  logic [TW-1:0]      tmr_val;
  logic               cur_bit, nxt_bit, last_bit, sh_load, sh_adv;

  assign sh_load = (st == S_IDLE) && start;
  assign sh_adv  = (st == S_BHI) && tz && !last_bit;

  clkprog_shifter #(.N(NBITS)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load),
    .din({prog_word, loc_addr, 3'b001}),
    .adv(sh_adv), .cur_bit(cur_bit), .nxt_bit(nxt_bit), .last(last_bit)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TW'(PHASE_CYC - 1);
    unique case (st)
      S_IDLE: tmr_load = start;
      S_CLR: begin tmr_load = tz; tmr_val = TW'(BLANK_CYC - 1); end
      S_RST: begin tmr_load = tz; tmr_val = TW'(SETTLE_CYC - 1); end
      S_BHI: begin
        tmr_load = tz;
        if (last_bit) tmr_val = TW'(POST_CYC - 1);
      end
      default: tmr_load = tz;
    endcase
  end

  clkprog_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .zero(tz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;  ctl_q <= '0;  saved_q <= '0;  loc_q <= '0;
      pend <= 1'b0;  strobe_q <= 1'b0;  blank_q <= 1'b0;  done_q <= 1'b0;
    end else begin
      strobe_q <= pend;
      pend     <= 1'b0;
      done_q   <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          saved_q <= ctl_in;  loc_q <= loc_addr;
          ctl_q <= '0;  blank_q <= 1'b1;  pend <= 1'b1;  st <= S_CLR;
        end
        S_CLR:  if (tz) st <= S_GRD1;
        S_GRD1: if (tz) begin ctl_q <= '0; pend <= 1'b1; st <= S_PRE0; end
        S_PRE0: if (tz) begin
          ctl_q <= CTL_W'(1) << ANC_POS;  pend <= 1'b1;  st <= S_PRE1;
        end
        S_PRE1: if (tz) begin
          ctl_q <= bit_word(cur_bit, 1'b0);  pend <= 1'b1;  st <= S_BLO;
        end
        S_BLO:  if (tz) begin
          ctl_q <= bit_word(cur_bit, 1'b1);  pend <= 1'b1;  st <= S_BHI;
        end
        S_BHI:  if (tz) begin
          if (last_bit) st <= S_TAIL;
          else begin
            ctl_q <= bit_word(nxt_bit, 1'b0);  pend <= 1'b1;  st <= S_BLO;
          end
        end
        S_TAIL: if (tz) begin
          ctl_q <= saved_q | STB_MASK;  blank_q <= 1'b0;  pend <= 1'b1;  st <= S_RST;
        end
        S_RST:  if (tz) st <= S_GRD2;
        S_GRD2: if (tz) begin
          ctl_q <= CTL_W'(loc_q[SEL_W-1:0]) | STB_MASK;  pend <= 1'b1;  st <= S_FIN;
        end
        S_FIN:  if (tz) begin done_q <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ctl_o    = ctl_q;
  assign strobe_o = strobe_q;
  assign sdat_o   = ctl_q[DAT_POS];
  assign sclk_o   = ctl_q[CLK_POS];
  assign blank_o  = blank_q;
  assign done_o   = done_q;

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
    strobe_q |=> !strobe_q);
  a_r3_ctl_held: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> $stable(ctl_q));
  a_r6_blank_in_stream: assert property (@(posedge clk) disable iff (rst)
    (st == S_BLO || st == S_BHI) |-> blank_q);
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r10_busy_start: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE && start) |=> ($stable(saved_q) && $stable(loc_q)));
endmodule

// File: tb/clkprog_serial_bench.sv
module clkprog_serial_bench;
  localparam int PH = 4, BL = 25, PO = 7, SE = 40;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [4:0]  loc_addr = '0;
  logic [12:0] prog_word = '0;
  logic [7:0]  ctl_in = '0;
  logic [7:0]  ctl_o;
  logic strobe_o, sdat_o, sclk_o, blank_o, done_o;

  clkprog_serial #(.PHASE_CYC(PH), .BLANK_CYC(BL), .POST_CYC(PO), .SETTLE_CYC(SE))
  u_clkprog_serial (
    .clk(clk), .rst(rst), .start(start), .loc_addr(loc_addr), .prog_word(prog_word),
    .ctl_in(ctl_in), .ctl_o(ctl_o), .strobe_o(strobe_o), .sdat_o(sdat_o),
    .sclk_o(sclk_o), .blank_o(blank_o), .done_o(done_o)
  );

  always #2 clk = ~clk;  // 250 MHz

  typedef struct { logic [7:0] ctl; logic blank; int gap; int req; } item_t;
  item_t q[$];
  int tests = 0, fails = 0, cyc = 0, last_stb = 0, done_cnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] c, input logic b, input int g, input int r);
    item_t it;
    it.ctl = c; it.blank = b; it.gap = g; it.req = r;
    q.push_back(it);
  endtask

  // monitor: compares each strobed write against the scoreboard
  always @(negedge clk) if (!rst) begin
    if (strobe_o) begin
      if (q.size() == 0) chk(1'b0, "R10", "unexpected strobe", ctl_o, 0);
      else begin
        item_t e;
        string rq;
        e = q.pop_front();
        rq = $sformatf("R%0d", e.req);
        chk(ctl_o == e.ctl, rq, "ctl value", ctl_o, e.ctl);
        chk(blank_o == e.blank, rq, "blank", blank_o, e.blank);
        if (e.gap != 0) chk(cyc - last_stb == e.gap, rq, "strobe gap", cyc - last_stb, e.gap);
        chk(sdat_o == ctl_o[2] && sclk_o == ctl_o[3], "R6", "line mirror",
            {sclk_o, sdat_o}, ctl_o[3:2]);
      end
      last_stb = cyc;
    end
    if (done_o) begin
      done_cnt++;
      chk(cyc - last_stb == PH - 1, "R9", "done delay", cyc - last_stb, PH - 1);
      chk(q.size() == 0, "R9", "writes left at done", q.size(), 0);
    end
  end

  task automatic run_xfer(input logic [4:0] a, input logic [12:0] w,
                          input logic [7:0] c0, input bit inject);
    logic [20:0] s;
    int d0;
    s = {w, a, 3'b001};
    push(8'h00, 1'b1, 0, 2);                 // R2 clear + blank
    push(8'h00, 1'b1, PH + BL, 4);           // R4 guard, R5 preamble 0
    push(8'h01, 1'b1, PH, 5);                // R5 preamble 1
    for (int i = 0; i < 21; i++) begin       // R6 stream, R3 spacing
      push(8'h01 | (8'(s[i]) << 2), 1'b1, PH, 6);
      push(8'h09 | (8'(s[i]) << 2), 1'b1, PH, 6);
    end
    push(c0 | 8'h40, 1'b0, PH + PO, 7);      // R7 restore
    push({4'b0, a[3:0]} | 8'h40, 1'b0, PH + SE, 8);  // R8 select
    d0 = done_cnt;
    @(negedge clk);
    loc_addr = a; prog_word = w; ctl_in = c0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; loc_addr = ~a; prog_word = ~w; ctl_in = ~c0;
    if (inject) begin                        // R10 start while busy
      repeat (60) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9", "done pulses", done_cnt - d0, 1);
    chk(done_o == 1'b0, "R9", "done low after pulse", done_o, 0);
    chk(ctl_o == ({4'b0, a[3:0]} | 8'h40), "R8", "final ctl held", ctl_o,
        {4'b0, a[3:0]} | 8'h40);
    chk(blank_o == 1'b0, "R7", "blank released", blank_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ctl_o == 8'h00, "R1", "ctl", ctl_o, 0);
    chk({strobe_o, blank_o, done_o, sdat_o, sclk_o} == 5'b0, "R1", "flags",
        {strobe_o, blank_o, done_o, sdat_o, sclk_o}, 0);
    run_xfer(5'h00, 13'h0000, 8'h00, 1'b0);
    run_xfer(5'h1F, 13'h1FFF, 8'hA5, 1'b0);
    run_xfer(5'h15, 13'h0AB3, 8'h7F, 1'b1);
    run_xfer(5'h0A, 13'h1542, 8'h3C, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule